// File: doc/BRIEF.md
# Integer ALU with Signed/Unsigned Arithmetic and Compare Flags

This block is the integer execution unit of a 32-bit load/store datapath. One operation code picks among wrapping add and subtract (each in a signed and an unsigned variant), four bitwise logic functions, and signed and unsigned set-on-less-than. A single adder serves every arithmetic and compare operation. Subtraction is formed as A plus the inverted B plus one.

Besides the result, the block reports a zero flag and a signed-overflow flag. A branch unit tests two registers for equality by issuing a subtract and looking at the zero flag. Operands arrive already widened to the datapath width.

The computing core is purely combinational. A thin registered stage at the top captures the result and the flags on each rising clock edge, so outputs appear one cycle after the inputs are presented.

Top module: `int_alu`

## Requirements
- R1: Code 0x0 (signed add) and code 0x1 (unsigned add) give opA + opB modulo 2^32.
- R2: Code 0x2 (signed subtract) and code 0x3 (unsigned subtract) give opA - opB modulo 2^32.
- R3: Code 0x4 gives opA AND opB, 0x5 gives OR, 0x6 gives XOR and 0x7 gives NOR (the inverted OR).
- R4: Code 0xA gives 1 when opA < opB as two's-complement numbers and 0 otherwise. This holds even when opA - opB overflows.
- R5: Code 0xB gives 1 when opA < opB as unsigned numbers and 0 otherwise.
- R6: For codes 0xA and 0xB, result bits 31 down to 1 are always 0, and the answer sits in bit 0.
- R7: zeroFlag is 1 exactly when all 32 result bits are 0. A subtract of two equal operands therefore raises it.
- R8: For codes 0x0 and 0x2, ovfFlag is 1 exactly when the true signed result does not fit in 32 bits.
- R9: For codes 0x1 and 0x3, ovfFlag is always 0.
- R10: For codes 0x4 through 0x7, 0xA and 0xB, ovfFlag is always 0.
- R11: Codes 0x8, 0x9 and 0xC through 0xF give result 0 and ovfFlag 0, whatever the operands.
- R12: Outputs reflect the inputs present at the previous rising clock edge. While rstN is low, result is 0, zeroFlag is 1 and ovfFlag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs are captured on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output stage |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 4 | Operation select |
| result | output | 32 | Registered operation result |
| zeroFlag | output | 1 | Registered all-zero indication of result |
| ovfFlag | output | 1 | Registered signed-overflow indication |

## Verification
Several properties are checked on every clock edge after reset:
- compare results have bits 31..1 clear;
- the unsigned, logic, compare and unused codes never raise overflow;
- unused codes yield zero;
- the zero flag always agrees with the result;
- a signed add whose operand signs agree but whose sum sign differs always flags overflow.

The bench's scenarios are what show the arithmetic values themselves. These include the subtract-overflow cases and the signed compare that stays correct across an overflowing difference. The scenarios also show the unsigned compare around the top of the range and the one-cycle latency and reset values.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_SUM   = 2'd1,
    RES_LOGIC = 2'd2,
    RES_LESS  = 2'd3
  } resSel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2,
    LOG_NOR = 2'd3
  } logicSel_e;

  typedef struct packed {
    logic      invertB;
    logic      carryIn;
    logicSel_e logicSel;
    resSel_e   resSel;
    logic      sltSigned;
    logic      ovfEn;
  } aluStrobes_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '{invertB: 1'b0, carryIn: 1'b0, logicSel: LOG_AND,
                resSel: RES_NONE, sltSigned: 1'b0, ovfEn: 1'b0};
    case (opCode)
      OP_ADD: begin
        strobes.resSel = RES_SUM;
        strobes.ovfEn  = 1'b1;
      end
      OP_ADDU: strobes.resSel = RES_SUM;
      OP_SUB: begin
        strobes.resSel  = RES_SUM;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
        strobes.ovfEn   = 1'b1;
      end
      OP_SUBU: begin
        strobes.resSel  = RES_SUM;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      OP_AND: begin strobes.resSel = RES_LOGIC; strobes.logicSel = LOG_AND; end
      OP_OR:  begin strobes.resSel = RES_LOGIC; strobes.logicSel = LOG_OR;  end
      OP_XOR: begin strobes.resSel = RES_LOGIC; strobes.logicSel = LOG_XOR; end
      OP_NOR: begin strobes.resSel = RES_LOGIC; strobes.logicSel = LOG_NOR; end
      OP_SLT: begin
        strobes.resSel    = RES_LESS;
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.sltSigned = 1'b1;
      end
      OP_SLTU: begin
        strobes.resSel  = RES_LESS;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] resComb,
  output logic              zeroComb,
  output logic              ovfComb
);

  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] bOperand;
  logic [LOW_W-1:0]  lowSum;
  logic              cIntoMsb;
  logic              msbSum;
  logic              cOutMsb;
  logic [DATA_W-1:0] sumVal;
  logic              ovfRaw;
  logic              lessBit;
  logic [DATA_W-1:0] logicVal;

  assign bOperand = strobes.invertB ? ~opB : opB;

  // Split adder: the low part exposes the carry into the sign bit.
  assign {cIntoMsb, lowSum} = {1'b0, opA[LOW_W-1:0]} + {1'b0, bOperand[LOW_W-1:0]}
                              + {{LOW_W{1'b0}}, strobes.carryIn};
  assign {cOutMsb, msbSum}  = {1'b0, opA[DATA_W-1]} + {1'b0, bOperand[DATA_W-1]}
                              + {1'b0, cIntoMsb};
  assign sumVal = {msbSum, lowSum};
  assign ovfRaw = cIntoMsb ^ cOutMsb;

  // Signed: sign of difference corrected by overflow. Unsigned: borrow.
  assign lessBit = strobes.sltSigned ? (msbSum ^ ovfRaw) : ~cOutMsb;

  for (genvar i = 0; i < DATA_W; i++) begin : g_logic
    always_comb begin
      case (strobes.logicSel)
        LOG_AND: logicVal[i] = opA[i] & opB[i];
        LOG_OR:  logicVal[i] = opA[i] | opB[i];
        LOG_XOR: logicVal[i] = opA[i] ^ opB[i];
        default: logicVal[i] = ~(opA[i] | opB[i]);
      endcase
    end
  end

  always_comb begin
    case (strobes.resSel)
      RES_SUM:   resComb = sumVal;
      RES_LOGIC: resComb = logicVal;
      RES_LESS:  resComb = {{LOW_W{1'b0}}, lessBit};
      default:   resComb = '0;
    endcase
  end

  assign zeroComb = ~|resComb;
  assign ovfComb  = strobes.ovfEn & ovfRaw;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  aluStrobes_t       strobes;
  logic [DATA_W-1:0] resComb;
  logic              zeroComb;
  logic              ovfComb;
  logic              liveQ;

  int_alu_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  int_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .resComb  (resComb),
    .zeroComb (zeroComb),
    .ovfComb  (ovfComb)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      zeroFlag <= 1'b1;
      ovfFlag  <= 1'b0;
      liveQ    <= 1'b0;
    end else begin
      result   <= resComb;
      zeroFlag <= zeroComb;
      ovfFlag  <= ovfComb;
      liveQ    <= 1'b1;
    end
  end

  assert_zero_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag == (result == '0));

  assert_less_shape_R6: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && ($past(opCode) == OP_SLT || $past(opCode) == OP_SLTU)
    |-> result[DATA_W-1:1] == '0);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && ($past(opCode) == OP_ADDU || $past(opCode) == OP_SUBU) |-> !ovfFlag);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && ($past(opCode) >= OP_AND && $past(opCode) <= OP_NOR
              || $past(opCode) == OP_SLT || $past(opCode) == OP_SLTU) |-> !ovfFlag);

  assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && ($past(opCode) == 4'h8 || $past(opCode) == 4'h9 || $past(opCode) >= 4'hC)
    |-> (result == '0) && !ovfFlag);

  assert_add_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    liveQ && $past(opCode) == OP_ADD && $past(opA[DATA_W-1]) == $past(opB[DATA_W-1])
    && result[DATA_W-1] != $past(opA[DATA_W-1]) |-> ovfFlag);

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        ovfFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0]  op;
    logic [31:0] expRes;
    logic        expZero;
    logic        expOvf;
    string       tag;
  } item_t;

  item_t scoreQ[$];

  always #2 clk = ~clk;

  int_alu u_int_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  function automatic string tagOf(logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R3";
      4'hA: return "R4";
      4'hB: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    item_t it;
    logic [31:0] r;
    logic ov;
    ov = 1'b0;
    case (op)
      4'h0, 4'h1: r = a + b;
      4'h2, 4'h3: r = a - b;
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'hB: r = (a < b) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    if (op == 4'h0) ov = (a[31] == b[31]) && (r[31] != a[31]);
    if (op == 4'h2) ov = (a[31] != b[31]) && (r[31] != a[31]);
    @(negedge clk);
    opCode = op; opA = a; opB = b;
    it.op = op; it.expRes = r; it.expZero = (r == 32'd0); it.expOvf = ov;
    it.tag = (tag == "") ? tagOf(op) : tag;
    scoreQ.push_back(it);
  endtask

  // Monitor: results show one edge after the driving negedge (R12).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        item_t it;
        it = scoreQ.pop_front();
        checks++;
        if (result !== it.expRes || zeroFlag !== it.expZero || ovfFlag !== it.expOvf) begin
          failures++;
          $display("FAIL %s op=%h actual res=%h zero=%b ovf=%b expected res=%h zero=%b ovf=%b",
                   it.tag, it.op, result, zeroFlag, ovfFlag, it.expRes, it.expZero, it.expOvf);
        end
      end
    end
  end

  task automatic checkReset(input string when);
    checks++;
    if (result !== 32'd0 || zeroFlag !== 1'b1 || ovfFlag !== 1'b0) begin
      failures++;
      $display("FAIL R12 reset(%s) actual res=%h zero=%b ovf=%b expected res=0 zero=1 ovf=0",
               when, result, zeroFlag, ovfFlag);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opCode = 4'h0; opA = 32'h1234_5678; opB = 32'h1111_1111;
    repeat (3) @(posedge clk);
    #1 checkReset("start");  // R12
    @(negedge clk) rstN = 1'b1;

    drive(4'h0, 32'd5, 32'd7, "R1");
    drive(4'h0, 32'h7FFF_FFFF, 32'd1, "R8");
    drive(4'h1, 32'h7FFF_FFFF, 32'd1, "R9");
    drive(4'h0, 32'h8000_0000, 32'h8000_0000, "R8");
    drive(4'h1, 32'hFFFF_FFFF, 32'd1, "R9");
    drive(4'h2, 32'd10, 32'd10, "R7");
    drive(4'h2, 32'h8000_0000, 32'd1, "R8");
    drive(4'h2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R8");
    drive(4'h3, 32'd3, 32'd5, "R2");
    drive(4'h3, 32'h8000_0000, 32'd1, "R9");
    drive(4'h4, 32'hF0F0_1234, 32'h0FF0_FF00, "R3");
    drive(4'h5, 32'hF0F0_1234, 32'h0FF0_FF00, "R3");
    drive(4'h6, 32'hF0F0_1234, 32'hF0F0_1234, "R7");
    drive(4'h7, 32'hF0F0_1234, 32'h0FF0_FF00, "R3");
    drive(4'hA, 32'hFFFF_FFFF, 32'd1, "R4");
    drive(4'hA, 32'h8000_0000, 32'd1, "R4");
    drive(4'hA, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R4");
    drive(4'hA, 32'd9, 32'd9, "R6");
    drive(4'hB, 32'd1, 32'hFFFF_FFFF, "R5");
    drive(4'hB, 32'hFFFF_FFFF, 32'd1, "R5");
    drive(4'hB, 32'd4, 32'd4, "R6");
    drive(4'h4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10");
    drive(4'hA, 32'h8000_0000, 32'h7FFF_FFFF, "R10");
    for (int c = 8; c < 16; c++) begin
      if (c != 10 && c != 11) drive(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R11");
    end
    for (int n = 0; n < 400; n++) begin
      drive(4'($urandom_range(15)), $urandom(), (n % 7 == 0) ? 32'h8000_0000 : $urandom(), "");
    end

    wait (scoreQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    opCode = 4'h0; opA = 32'h7FFF_FFFF; opB = 32'd1;
    @(posedge clk);
    #1 checkReset("mid-run");  // R12
    @(negedge clk) rstN = 1'b1;
    drive(4'h2, 32'd100, 32'd58, "R12");
    repeat (3) @(posedge clk);
    #1;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule